// File: doc/BRIEF.md
# In-Order Multi-Issue Scoreboard

This block is the issue-control stage of an in-order machine that can start several instructions in one clock. Each cycle it sees a small window of decoded instructions, oldest in slot 0. Every slot carries a valid bit, an instruction-class code, a destination register and two source registers. Register 0 stands for "no operand". The block decides how many of the oldest slots issue this cycle. For each issued slot it also names the copy of the functional unit that takes it.

Two kinds of timing are tracked separately. The first is result readiness per register. It comes from the operation latency of the producer's class. The second is a busy timer per functional-unit copy. It comes from the issue latency of that unit type. Each unit type has a parameter for how many copies it has. A global cap limits how many instructions can leave in one cycle. The surrounding pipeline removes the issued prefix from the window and refills it.

Top module: `mi_issue_ctl`

## Requirements
- R1: Issue is in program order. The issued slots are always slots 0 to issue_cnt-1. A slot that cannot issue holds back every younger slot, even when the younger slot is free of hazards.
- R2: A slot whose valid bit is low never issues, and no slot after it issues in that cycle.
- R3: A consumer whose source register (either source field) is the destination of an earlier producer cannot issue until that producer's operation latency has elapsed. The first cycle in which the consumer may issue is the producer's issue cycle plus its latency.
- R4: The default class codes and operation latencies are: 0 = ALU with 1 cycle, 1 = load with 2, 2 = store with 2, 3 = branch with 2, 4 = floating point with 3.
- R5: A consumer in the same window whose producer issues in the same cycle does not issue in that cycle.
- R6: Register 0 is always ready. Writing it creates no dependency, either in the same cycle or across cycles.
- R7: The default unit types are: ALU (classes 0) with 2 copies, memory (classes 1 and 2) with 1 copy, branch (class 3) with 1 copy, and floating point (class 4) with 2 copies. An issued slot takes the lowest-numbered copy of its unit that is idle and not already taken this cycle. issue_copy holds that copy number, KW bits per slot, with slot 0 in the least significant field.
- R8: A copy that accepts an instruction is busy for the issue latency of its unit type, counted in cycles. The defaults are 1 for ALU, memory and branch, and 2 for floating point. Issue latency is independent of operation latency.
- R9: Suppose a slot needs a unit type whose copies are all busy or already taken in this cycle. That slot does not issue, and issue stops for the rest of the cycle.
- R10: No more than ISSUE_CAP slots (default 3) issue in one cycle, even when units and operands are free.
- R11: While rst is high, issue_cnt is 0. A synchronous reset clears every register and copy timer, so the first cycle after reset sees all registers ready and all copies idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_vld | input | WIN | Valid bit per window slot, slot 0 oldest |
| slot_cls | input | WIN*CW | Class code per slot |
| slot_dst | input | WIN*RW | Destination register per slot |
| slot_src0 | input | WIN*RW | First source register per slot |
| slot_src1 | input | WIN*RW | Second source register per slot |
| issue_cnt | output | NW | Number of oldest slots issued this cycle |
| issue_copy | output | WIN*KW | Chosen unit copy per slot, zero for slots not issued |

## Verification
The window is filled with several kinds of pattern.

- Independent mixed classes show that the width cap is the only limit.
- Three ALU operations followed by a load show that the cycle stops at the third ALU operation.
- A load and a store together fight over the single memory copy.
- Back-to-back floating-point operations show that busy copies rotate and that the lowest idle copy is chosen.
- Dependent pairs built on an ALU operation, a load and a floating-point producer stall for exactly 0, 1 and 2 cycles. This separates the per-class operation latencies from one another, and from the same-cycle block and the register-0 exemption.
- A hazard-free instruction placed behind a stalled one, and a gap left by an empty slot, both show that younger slots are never issued past an older one.

// File: rtl/mi_issue_pkg.sv
package mi_issue_pkg;
   // Field width used for every latency, unit index and multiplicity parameter
   localparam int FLD_W = 4;

   // Default class codes
   localparam int CLS_ALU    = 0;
   localparam int CLS_LOAD   = 1;
   localparam int CLS_STORE  = 2;
   localparam int CLS_BRANCH = 3;
   localparam int CLS_FP     = 4;

   // Minimum-one bit count to index n items
   function automatic int bits_for(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/mi_reg_track.sv
module mi_reg_track
   import mi_issue_pkg::*;
#(
   parameter int WIN  = 4,
   parameter int NREG = 32,
   localparam int RW  = bits_for(NREG)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [WIN-1:0]       grant,
   input  logic [WIN*RW-1:0]    grant_dst,
   input  logic [WIN*FLD_W-1:0] grant_lat,
   output logic [NREG-1:0]      reg_busy
);
   // Register 0 has no timer; every other register counts down to ready
   assign reg_busy[0] = 1'b0;

   for (genvar r = 1; r < NREG; r++) begin : g_reg
      logic [FLD_W-1:0] cnt_q;
      logic             ld;
      logic [FLD_W-1:0] ld_val;

      // Younger slot in the same cycle overrides an older write
      always_comb begin
         ld     = 1'b0;
         ld_val = '0;
         for (int i = 0; i < WIN; i++) begin
            if (grant[i] && grant_dst[i*RW +: RW] == RW'(r)) begin
               ld     = 1'b1;
               ld_val = grant_lat[i*FLD_W +: FLD_W] - FLD_W'(1);
            end
         end
      end

      always_ff @(posedge clk) begin
         if (rst)               cnt_q <= '0;
         else if (ld)           cnt_q <= ld_val;
         else if (cnt_q != '0)  cnt_q <= cnt_q - FLD_W'(1);
      end

      assign reg_busy[r] = (cnt_q != '0);
   end
endmodule

// File: rtl/mi_unit_pool.sv
module mi_unit_pool
   import mi_issue_pkg::*;
#(
   parameter int WIN     = 4,
   parameter int NUNIT   = 4,
   parameter int MAXMULT = 2,
   parameter logic [NUNIT*FLD_W-1:0] UNIT_MULT   = {4'd2, 4'd1, 4'd1, 4'd2},
   parameter logic [NUNIT*FLD_W-1:0] UNIT_ISSLAT = {4'd2, 4'd1, 4'd1, 4'd1},
   localparam int KW = bits_for(MAXMULT)
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [WIN-1:0]             grant,
   input  logic [WIN*FLD_W-1:0]       grant_unit,
   input  logic [WIN*KW-1:0]          grant_copy,
   output logic [NUNIT*MAXMULT-1:0]   copy_busy
);
   for (genvar u = 0; u < NUNIT; u++) begin : g_unit
      localparam int MULT = int'(UNIT_MULT[u*FLD_W +: FLD_W]);
      localparam logic [FLD_W-1:0] HOLD = UNIT_ISSLAT[u*FLD_W +: FLD_W] - FLD_W'(1);

      for (genvar k = 0; k < MAXMULT; k++) begin : g_copy
         if (k < MULT) begin : g_real
            logic [FLD_W-1:0] tmr_q;
            logic             hit;

            always_comb begin
               hit = 1'b0;
               for (int i = 0; i < WIN; i++) begin
                  if (grant[i] && grant_unit[i*FLD_W +: FLD_W] == FLD_W'(u)
                      && grant_copy[i*KW +: KW] == KW'(k))
                     hit = 1'b1;
               end
            end

            always_ff @(posedge clk) begin
               if (rst)              tmr_q <= '0;
               else if (hit)         tmr_q <= HOLD;
               else if (tmr_q != '0) tmr_q <= tmr_q - FLD_W'(1);
            end

            assign copy_busy[u*MAXMULT + k] = (tmr_q != '0);
         end else begin : g_absent
            // Copy not built for this unit type: permanently unavailable
            assign copy_busy[u*MAXMULT + k] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/mi_issue_sel.sv
module mi_issue_sel
   import mi_issue_pkg::*;
#(
   parameter int WIN       = 4,
   parameter int NREG      = 32,
   parameter int NCLS      = 5,
   parameter int NUNIT     = 4,
   parameter int MAXMULT   = 2,
   parameter int ISSUE_CAP = 3,
   parameter logic [NCLS*FLD_W-1:0] CLS_OPLAT = {4'd3, 4'd2, 4'd2, 4'd2, 4'd1},
   parameter logic [NCLS*FLD_W-1:0] CLS_UNIT  = {4'd3, 4'd2, 4'd1, 4'd1, 4'd0},
   localparam int RW = bits_for(NREG),
   localparam int CW = bits_for(NCLS),
   localparam int KW = bits_for(MAXMULT),
   localparam int NW = $clog2(WIN + 1)
) (
   input  logic                     hold,
   input  logic [WIN-1:0]           slot_vld,
   input  logic [WIN*CW-1:0]        slot_cls,
   input  logic [WIN*RW-1:0]        slot_dst,
   input  logic [WIN*RW-1:0]        slot_src0,
   input  logic [WIN*RW-1:0]        slot_src1,
   input  logic [NREG-1:0]          reg_busy,
   input  logic [NUNIT*MAXMULT-1:0] copy_busy,
   output logic [WIN-1:0]           grant,
   output logic [NW-1:0]            grant_cnt,
   output logic [WIN*KW-1:0]        grant_copy,
   output logic [WIN*FLD_W-1:0]     grant_unit,
   output logic [WIN*FLD_W-1:0]     grant_lat
);
   always_comb begin
      logic                     stop;
      logic                     ok;
      logic                     found;
      logic                     cls_ok;
      logic                     s0_ok;
      logic                     s1_ok;
      logic [NUNIT*MAXMULT-1:0] taken;
      logic [NREG-1:0]          pend;
      logic [FLD_W-1:0]         unit;
      logic [FLD_W-1:0]         lat;
      logic [KW-1:0]            pick;
      logic [CW-1:0]            cls;
      logic [RW-1:0]            dst;
      logic [RW-1:0]            s0;
      logic [RW-1:0]            s1;
      int                       n;

      stop       = hold;
      taken      = '0;
      pend       = '0;
      n          = 0;
      grant      = '0;
      grant_copy = '0;
      grant_unit = '0;
      grant_lat  = '0;

      for (int i = 0; i < WIN; i++) begin
         cls = slot_cls[i*CW +: CW];
         dst = slot_dst[i*RW +: RW];
         s0  = slot_src0[i*RW +: RW];
         s1  = slot_src1[i*RW +: RW];

         // Class lookup: unit type and operation latency
         cls_ok = 1'b0;
         unit   = '0;
         lat    = FLD_W'(1);
         for (int c = 0; c < NCLS; c++) begin
            if (cls == CW'(c)) begin
               cls_ok = 1'b1;
               unit   = CLS_UNIT[c*FLD_W +: FLD_W];
               lat    = CLS_OPLAT[c*FLD_W +: FLD_W];
            end
         end

         // Lowest-numbered copy that is idle and not claimed by an older slot
         found = 1'b0;
         pick  = '0;
         for (int u = 0; u < NUNIT; u++) begin
            for (int k = 0; k < MAXMULT; k++) begin
               if (!found && unit == FLD_W'(u)
                   && !copy_busy[u*MAXMULT + k] && !taken[u*MAXMULT + k]) begin
                  found = 1'b1;
                  pick  = KW'(k);
               end
            end
         end

         // Operand readiness against older cycles and older slots of this cycle
         s0_ok = (s0 == '0) || (!reg_busy[s0] && !pend[s0]);
         s1_ok = (s1 == '0) || (!reg_busy[s1] && !pend[s1]);

         ok = !stop && slot_vld[i] && cls_ok && (n < ISSUE_CAP)
              && s0_ok && s1_ok && found;

         if (ok) begin
            grant[i]                       = 1'b1;
            grant_copy[i*KW +: KW]         = pick;
            grant_unit[i*FLD_W +: FLD_W]   = unit;
            grant_lat[i*FLD_W +: FLD_W]    = lat;
            n                              = n + 1;
            for (int u = 0; u < NUNIT; u++) begin
               for (int k = 0; k < MAXMULT; k++) begin
                  if (unit == FLD_W'(u) && pick == KW'(k))
                     taken[u*MAXMULT + k] = 1'b1;
               end
            end
            if (dst != '0) pend[dst] = 1'b1;
         end else begin
            stop = 1'b1;
         end
      end

      grant_cnt = NW'(n);
   end
endmodule

// File: rtl/mi_issue_ctl.sv
module mi_issue_ctl
   import mi_issue_pkg::*;
#(
   parameter int WIN       = 4,
   parameter int NREG      = 32,
   parameter int NCLS      = 5,
   parameter int NUNIT     = 4,
   parameter int MAXMULT   = 2,
   parameter int ISSUE_CAP = 3,
   parameter logic [NCLS*FLD_W-1:0]  CLS_OPLAT   = {4'd3, 4'd2, 4'd2, 4'd2, 4'd1},
   parameter logic [NCLS*FLD_W-1:0]  CLS_UNIT    = {4'd3, 4'd2, 4'd1, 4'd1, 4'd0},
   parameter logic [NUNIT*FLD_W-1:0] UNIT_MULT   = {4'd2, 4'd1, 4'd1, 4'd2},
   parameter logic [NUNIT*FLD_W-1:0] UNIT_ISSLAT = {4'd2, 4'd1, 4'd1, 4'd1},
   localparam int RW = bits_for(NREG),
   localparam int CW = bits_for(NCLS),
   localparam int KW = bits_for(MAXMULT),
   localparam int NW = $clog2(WIN + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WIN-1:0]    slot_vld,
   input  logic [WIN*CW-1:0] slot_cls,
   input  logic [WIN*RW-1:0] slot_dst,
   input  logic [WIN*RW-1:0] slot_src0,
   input  logic [WIN*RW-1:0] slot_src1,
   output logic [NW-1:0]     issue_cnt,
   output logic [WIN*KW-1:0] issue_copy
);
   // Elaboration-time parameter checks
   if (WIN < 1)                           $error("window must hold at least one slot");
   if (NCLS < 1 || NCLS > 14)             $error("class count out of range");
   if (NUNIT < 1 || NUNIT > 16)           $error("unit type count out of range");
   if (MAXMULT < 1 || MAXMULT > 15)       $error("copy bound out of range");
   if (ISSUE_CAP < 1 || ISSUE_CAP > WIN)  $error("issue cap out of range");
   if (NREG < 2 || NREG != (1 << RW))     $error("register count must be a power of two");
   for (genvar c = 0; c < NCLS; c++) begin : g_cls_chk
      if (CLS_OPLAT[c*FLD_W +: FLD_W] == '0)            $error("operation latency must be nonzero");
      if (int'(CLS_UNIT[c*FLD_W +: FLD_W]) >= NUNIT)    $error("class maps to missing unit");
   end
   for (genvar u = 0; u < NUNIT; u++) begin : g_unit_chk
      if (UNIT_ISSLAT[u*FLD_W +: FLD_W] == '0)          $error("issue latency must be nonzero");
      if (UNIT_MULT[u*FLD_W +: FLD_W] == '0
          || int'(UNIT_MULT[u*FLD_W +: FLD_W]) > MAXMULT) $error("multiplicity out of range");
   end

   logic [NREG-1:0]          reg_busy;
   logic [NUNIT*MAXMULT-1:0] copy_busy;
   logic [WIN-1:0]           grant;
   logic [WIN*FLD_W-1:0]     grant_unit;
   logic [WIN*FLD_W-1:0]     grant_lat;

   mi_issue_sel #(
      .WIN(WIN), .NREG(NREG), .NCLS(NCLS), .NUNIT(NUNIT), .MAXMULT(MAXMULT),
      .ISSUE_CAP(ISSUE_CAP), .CLS_OPLAT(CLS_OPLAT), .CLS_UNIT(CLS_UNIT)
   ) sel_i (
      .hold(rst), .slot_vld(slot_vld), .slot_cls(slot_cls), .slot_dst(slot_dst),
      .slot_src0(slot_src0), .slot_src1(slot_src1), .reg_busy(reg_busy),
      .copy_busy(copy_busy), .grant(grant), .grant_cnt(issue_cnt),
      .grant_copy(issue_copy), .grant_unit(grant_unit), .grant_lat(grant_lat)
   );

   mi_reg_track #(.WIN(WIN), .NREG(NREG)) regs_i (
      .clk(clk), .rst(rst), .grant(grant), .grant_dst(slot_dst),
      .grant_lat(grant_lat), .reg_busy(reg_busy)
   );

   mi_unit_pool #(
      .WIN(WIN), .NUNIT(NUNIT), .MAXMULT(MAXMULT),
      .UNIT_MULT(UNIT_MULT), .UNIT_ISSLAT(UNIT_ISSLAT)
   ) pool_i (
      .clk(clk), .rst(rst), .grant(grant), .grant_unit(grant_unit),
      .grant_copy(issue_copy), .copy_busy(copy_busy)
   );
endmodule

// File: rtl/mi_issue_chk.sv
module mi_issue_chk
   import mi_issue_pkg::*;
#(
   parameter int WIN       = 4,
   parameter int NREG      = 32,
   parameter int NCLS      = 5,
   parameter int NUNIT     = 4,
   parameter int MAXMULT   = 2,
   parameter int ISSUE_CAP = 3,
   parameter logic [NCLS*FLD_W-1:0]  CLS_UNIT  = {4'd3, 4'd2, 4'd1, 4'd1, 4'd0},
   parameter logic [NUNIT*FLD_W-1:0] UNIT_MULT = {4'd2, 4'd1, 4'd1, 4'd2},
   localparam int RW = bits_for(NREG),
   localparam int CW = bits_for(NCLS),
   localparam int KW = bits_for(MAXMULT),
   localparam int NW = $clog2(WIN + 1)
) (
   input logic              clk,
   input logic              rst,
   input logic [WIN-1:0]    slot_vld,
   input logic [WIN*CW-1:0] slot_cls,
   input logic [WIN*RW-1:0] slot_dst,
   input logic [WIN*RW-1:0] slot_src0,
   input logic [WIN*RW-1:0] slot_src1,
   input logic [NW-1:0]     issue_cnt,
   input logic [WIN*KW-1:0] issue_copy
);
   logic [FLD_W-1:0] u_of [WIN];
   logic [FLD_W-1:0] m_of [WIN];

   always_comb begin
      for (int i = 0; i < WIN; i++) begin
         u_of[i] = '0;
         m_of[i] = '0;
         for (int c = 0; c < NCLS; c++) begin
            if (slot_cls[i*CW +: CW] == CW'(c)) u_of[i] = CLS_UNIT[c*FLD_W +: FLD_W];
         end
         for (int u = 0; u < NUNIT; u++) begin
            if (u_of[i] == FLD_W'(u)) m_of[i] = UNIT_MULT[u*FLD_W +: FLD_W];
         end
      end
   end

   // R10
   cap_limit_chk: assert property (@(posedge clk) disable iff (rst)
      int'(issue_cnt) <= ISSUE_CAP);

   // R11
   reset_quiet_chk: assert property (@(posedge clk)
      rst |-> issue_cnt == '0);

   for (genvar i = 0; i < WIN; i++) begin : g_slot
      // R2
      empty_stop_chk: assert property (@(posedge clk) disable iff (rst)
         !slot_vld[i] |-> int'(issue_cnt) <= i);

      // R7
      copy_exists_chk: assert property (@(posedge clk) disable iff (rst)
         int'(issue_cnt) > i |-> int'(issue_copy[i*KW +: KW]) < int'(m_of[i]));

      for (genvar j = i + 1; j < WIN; j++) begin : g_pair
         // R7
         copy_unique_chk: assert property (@(posedge clk) disable iff (rst)
            (int'(issue_cnt) > j && u_of[i] == u_of[j])
            |-> issue_copy[i*KW +: KW] != issue_copy[j*KW +: KW]);

         // R5
         same_cycle_raw_chk: assert property (@(posedge clk) disable iff (rst)
            (int'(issue_cnt) > j && slot_dst[i*RW +: RW] != '0)
            |-> (slot_src0[j*RW +: RW] != slot_dst[i*RW +: RW]
                 && slot_src1[j*RW +: RW] != slot_dst[i*RW +: RW]));
      end
   end
endmodule

bind mi_issue_ctl mi_issue_chk #(
   .WIN(WIN), .NREG(NREG), .NCLS(NCLS), .NUNIT(NUNIT), .MAXMULT(MAXMULT),
   .ISSUE_CAP(ISSUE_CAP), .CLS_UNIT(CLS_UNIT), .UNIT_MULT(UNIT_MULT)
) chk_i (.*);

// File: tb/mi_issue_ctl_tb_top.sv
module mi_issue_ctl_tb_top;
   import mi_issue_pkg::*;

   localparam int WIN = 4;
   localparam int RW  = 5;
   localparam int CW  = 3;
   localparam int KW  = 1;
   localparam int NW  = 3;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [WIN-1:0]    slot_vld = '0;
   logic [WIN*CW-1:0] slot_cls = '0;
   logic [WIN*RW-1:0] slot_dst = '0;
   logic [WIN*RW-1:0] slot_src0 = '0;
   logic [WIN*RW-1:0] slot_src1 = '0;
   logic [NW-1:0]     issue_cnt;
   logic [WIN*KW-1:0] issue_copy;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   mi_issue_ctl dut_i (
      .clk(clk), .rst(rst), .slot_vld(slot_vld), .slot_cls(slot_cls),
      .slot_dst(slot_dst), .slot_src0(slot_src0), .slot_src1(slot_src1),
      .issue_cnt(issue_cnt), .issue_copy(issue_copy)
   );

   task automatic win_clr();
      slot_vld = '0; slot_cls = '0; slot_dst = '0; slot_src0 = '0; slot_src1 = '0;
   endtask

   task automatic win_set(input int i, input int c, input int d, input int s0, input int s1);
      slot_vld[i]            = 1'b1;
      slot_cls[i*CW +: CW]   = CW'(c);
      slot_dst[i*RW +: RW]   = RW'(d);
      slot_src0[i*RW +: RW]  = RW'(s0);
      slot_src1[i*RW +: RW]  = RW'(s1);
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic drain();
      win_clr();
      repeat (4) tick();
   endtask

   task automatic chk_cnt(input string req, input int exp);
      #1;
      checks++;
      if (int'(issue_cnt) != exp) begin
         fails++;
         $display("FAIL %s issue_cnt actual=%0d expected=%0d at %0t", req, issue_cnt, exp, $time);
      end
   endtask

   task automatic chk_copy(input string req, input int i, input int exp);
      checks++;
      if (int'(issue_copy[i*KW +: KW]) != exp) begin
         fails++;
         $display("FAIL %s copy[%0d] actual=%0d expected=%0d at %0t",
                  req, i, issue_copy[i*KW +: KW], exp, $time);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      win_set(0, CLS_ALU, 1, 0, 0);
      chk_cnt("R11", 0);
      tick();
      rst = 1'b0;
      chk_cnt("R11", 1);
      drain();
   endtask

   task automatic t_cap();
      win_set(0, CLS_ALU, 1, 0, 0);
      win_set(1, CLS_LOAD, 2, 0, 0);
      win_set(2, CLS_BRANCH, 0, 0, 0);
      win_set(3, CLS_FP, 3, 0, 0);
      chk_cnt("R10", 3);
      chk_copy("R10", 0, 0); chk_copy("R10", 1, 0); chk_copy("R10", 2, 0);
      drain();
   endtask

   task automatic t_conflict();
      win_set(0, CLS_ALU, 1, 0, 0);
      win_set(1, CLS_ALU, 2, 0, 0);
      win_set(2, CLS_ALU, 3, 0, 0);
      win_set(3, CLS_LOAD, 4, 0, 0);
      chk_cnt("R9", 2);
      chk_copy("R7", 0, 0); chk_copy("R7", 1, 1);
      tick();
      win_clr();
      win_set(0, CLS_ALU, 3, 0, 0);
      win_set(1, CLS_LOAD, 4, 0, 0);
      chk_cnt("R9", 2);
      chk_copy("R8", 0, 0); chk_copy("R8", 1, 0);
      drain();
      // single memory copy shared by load and store
      win_set(0, CLS_LOAD, 15, 0, 0);
      win_set(1, CLS_STORE, 0, 0, 0);
      chk_cnt("R9", 1);
      tick();
      win_clr();
      win_set(0, CLS_STORE, 0, 0, 0);
      chk_cnt("R8", 1);
      drain();
   endtask

   task automatic t_empty();
      win_set(0, CLS_ALU, 1, 0, 0);
      win_set(2, CLS_ALU, 2, 0, 0);
      chk_cnt("R2", 1);
      drain();
   endtask

   task automatic t_alu_dep();
      win_set(0, CLS_ALU, 5, 0, 0);
      win_set(1, CLS_ALU, 17, 5, 0);
      chk_cnt("R5", 1);
      tick();
      win_clr();
      win_set(0, CLS_ALU, 17, 5, 0);
      chk_cnt("R3", 1);
      drain();
      win_set(0, CLS_ALU, 14, 0, 0);
      win_set(1, CLS_ALU, 18, 0, 14);
      chk_cnt("R5", 1);
      drain();
   endtask

   task automatic t_load_dep();
      win_set(0, CLS_LOAD, 6, 0, 0);
      chk_cnt("R4", 1);
      tick();
      win_clr();
      win_set(0, CLS_ALU, 16, 6, 0);
      win_set(1, CLS_ALU, 13, 0, 0);
      chk_cnt("R1", 0);
      tick();
      chk_cnt("R4", 2);
      drain();
   endtask

   task automatic t_fp_dep();
      win_set(0, CLS_FP, 7, 0, 0);
      chk_cnt("R4", 1);
      tick();
      win_clr();
      win_set(0, CLS_ALU, 19, 0, 7);
      chk_cnt("R3", 0);
      tick();
      chk_cnt("R3", 0);
      tick();
      chk_cnt("R4", 1);
      drain();
   endtask

   task automatic t_reg0();
      win_set(0, CLS_ALU, 0, 0, 0);
      win_set(1, CLS_ALU, 20, 0, 0);
      chk_cnt("R6", 2);
      drain();
   endtask

   task automatic t_fp_copies();
      win_set(0, CLS_FP, 8, 0, 0);
      win_set(1, CLS_FP, 9, 0, 0);
      chk_cnt("R7", 2);
      chk_copy("R7", 0, 0); chk_copy("R7", 1, 1);
      tick();
      win_clr();
      win_set(0, CLS_FP, 10, 0, 0);
      chk_cnt("R8", 0);
      tick();
      chk_cnt("R8", 1);
      chk_copy("R8", 0, 0);
      tick();
      win_clr();
      win_set(0, CLS_FP, 11, 0, 0);
      chk_cnt("R7", 1);
      chk_copy("R7", 0, 1);
      drain();
   endtask

   initial begin
      t_reset();
      t_cap();
      t_conflict();
      t_empty();
      t_alu_dep();
      t_load_dep();
      t_fp_dep();
      t_reg0();
      t_fp_copies();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog run did not complete");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule